// File: doc/BRIEF.md
# Double-Buffered Serial Word Transmitter

This block sends words of selectable length on a single serial data output. It is timed by an external serial clock and a frame-sync line, and both are oversampled by the system clock. The host loads a word through a 16-bit write port with a high/low select. The high half carries the top bits of words longer than 16 bits. Writing the low half completes the word.

A frame starts at an active serial clock edge where frame-sync is asserted. At that edge the held word is copied into a shift register and its first bit is driven. The hold register is then free again, so the host can load the next word while the current one is still going out. Words can follow each other with no gap.

A ready flag serves as the interrupt/DMA request that asks the host for the next word. A sticky underrun flag records a frame that started before fresh data arrived. In that case the old word is sent again.

Top module: `serial_word_tx`

## Requirements
- R1: After reset `sdata_o`=0, `tx_active_o`=0, `ready_o`=1 and `underrun_o`=0.
- R2: `cfg_len_i` selects the word length: 0=8, 1=12, 2=16, 3=20, 4=24, 5=32 bits (codes 6 and 7 also mean 32). A frame shifts exactly that many bits, one per active serial clock edge, with the first bit driven at the frame-start edge.
- R3: By default bits go out most significant first, so bit i of a frame (i=0 first) is word[L-1-i]. The word is `{high, low}` truncated to its L low bits.
- R4: With `cfg_lsb_first_i`=1 and an 8-bit length, bit i is word[i]. For every other length the option has no effect.
- R5: For lengths above 16, word bits 16 and up come from the high register. For lengths of 16 or less, the high register has no effect on the output.
- R6: `ready_o` goes low on a low-half write and high again when a frame loads the word. A high-half write does not change it.
- R7: If a frame starts while `ready_o`=1, `underrun_o` sets and stays set, and the previous word is sent again. A low-half write clears `underrun_o`.
- R8: `cfg_clk_pol_i`=0 makes the rising serial clock edge active, and 1 makes the falling edge active. The output changes only after an active edge.
- R9: `cfg_fs_pol_i`=0 means frame-sync is active high, and 1 means active low.
- R10: A frame-sync at the first active edge after a word's last bit starts the next word at once, with no idle bit between the two words.
- R11: Outside a word, `sdata_o` is held at 0 and `tx_active_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Host write strobe |
| wr_hi_i | input | 1 | 1 selects the high half, 0 the low half |
| wr_data_i | input | 16 | Host write data |
| cfg_len_i | input | 3 | Word length code |
| cfg_clk_pol_i | input | 1 | Active serial clock edge select |
| cfg_fs_pol_i | input | 1 | Frame-sync polarity |
| cfg_lsb_first_i | input | 1 | LSB-first for 8-bit words |
| sclk_i | input | 1 | Serial clock |
| fsync_i | input | 1 | Frame-sync |
| sdata_o | output | 1 | Serial data out |
| tx_active_o | output | 1 | High while a word is being shifted |
| ready_o | output | 1 | Hold register free (interrupt/DMA request) |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
The bench keeps the default 16-bit host port and two-stage synchronizer. It drives one serial clock period per eight system clocks, which leaves room for the three-cycle path from input edge to output. It sweeps all six length codes against both clock polarities, both frame polarities and both bit orders. Each configuration runs three frames: one with a back-to-back follow-on word and one that underruns. This covers every bit position of every length, the high register being ignored at short lengths, and the resent word after an underrun.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    LEN_8  = 3'd0,
    LEN_12 = 3'd1,
    LEN_16 = 3'd2,
    LEN_20 = 3'd3,
    LEN_24 = 3'd4,
    LEN_32 = 3'd5
  } len_code_e;

  // number of serial bits for a length code; unused codes map to 32
  function automatic logic [5:0] len_bits(input logic [2:0] code);
    case (code)
      LEN_8:   len_bits = 6'd8;
      LEN_12:  len_bits = 6'd12;
      LEN_16:  len_bits = 6'd16;
      LEN_20:  len_bits = 6'd20;
      LEN_24:  len_bits = 6'd24;
      default: len_bits = 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/sertx_sync_edge.sv
module sertx_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic fsync_i,
  input  logic clk_pol_i,
  input  logic fs_pol_i,
  output logic act_edge_o,
  output logic fs_act_o
);

  logic [SYNC_STAGES:0]   sclk_sh;
  logic [SYNC_STAGES-1:0] fs_sh;
  logic                   cur, prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_sh <= '0;
      fs_sh   <= '0;
    end else begin
      sclk_sh <= {sclk_sh[SYNC_STAGES-1:0], sclk_i};
      fs_sh   <= {fs_sh[SYNC_STAGES-2:0], fsync_i};
    end
  end

  assign cur  = sclk_sh[SYNC_STAGES-1];
  assign prev = sclk_sh[SYNC_STAGES];

  // rising edge when polarity is 0, falling edge when 1
  assign act_edge_o = clk_pol_i ? (prev & ~cur) : (cur & ~prev);
  assign fs_act_o   = fs_sh[SYNC_STAGES-1] ^ fs_pol_i;

endmodule

// File: rtl/sertx_hold_regs.sv
module sertx_hold_regs #(
  parameter int HOST_W = 16,
  localparam int WORD_W = 2 * HOST_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              wr_hi_i,
  input  logic [HOST_W-1:0] wr_data_i,
  input  logic              load_i,
  output logic [WORD_W-1:0] word_o,
  output logic              ready_o,
  output logic              underrun_o
);

  logic [HOST_W-1:0] hi_q, lo_q;
  logic              wr_lo, wr_hi;

  assign wr_lo = wr_en_i & ~wr_hi_i;
  assign wr_hi = wr_en_i &  wr_hi_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q       <= '0;
      lo_q       <= '0;
      ready_o    <= 1'b1;
      underrun_o <= 1'b0;
    end else begin
      if (wr_hi) hi_q <= wr_data_i;
      if (wr_lo) lo_q <= wr_data_i;
      // a low write completes a word; it wins over a same-cycle load
      if (wr_lo)       ready_o <= 1'b0;
      else if (load_i) ready_o <= 1'b1;
      if (wr_lo)                  underrun_o <= 1'b0;
      else if (load_i && ready_o) underrun_o <= 1'b1;
    end
  end

  assign word_o = {hi_q, lo_q};

  AST_READY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    (load_i && !wr_lo) |=> ready_o); // R6
  AST_HI_KEEPS_READY: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && !load_i) |=> $stable(ready_o)); // R6
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (underrun_o && !wr_lo) |=> underrun_o); // R7
  AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(underrun_o) |-> $past(load_i && ready_o)); // R7

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act_edge_i,
  input  logic              fs_act_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [2:0]        cfg_len_i,
  input  logic              lsb_first_i,
  output logic              load_o,
  output logic              sdata_o,
  output logic              busy_o
);

  logic [WORD_W-1:0] sr_q, msb_al;
  logic [CNT_W-1:0]  cnt_q;
  logic              dir_lsb_q, lsb_mode;
  logic [5:0]        nbits;

  assign nbits    = len_bits(cfg_len_i);
  assign lsb_mode = lsb_first_i && (cfg_len_i == LEN_8);
  assign msb_al   = word_i << (6'(WORD_W) - nbits);
  assign load_o   = act_edge_i & fs_act_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q      <= '0;
      cnt_q     <= '0;
      dir_lsb_q <= 1'b0;
      sdata_o   <= 1'b0;
      busy_o    <= 1'b0;
    end else if (act_edge_i) begin
      if (fs_act_i) begin
        busy_o    <= 1'b1;
        dir_lsb_q <= lsb_mode;
        cnt_q     <= CNT_W'(nbits - 6'd1);
        if (lsb_mode) begin
          sdata_o <= word_i[0];
          sr_q    <= word_i >> 1;
        end else begin
          sdata_o <= msb_al[WORD_W-1];
          sr_q    <= msb_al << 1;
        end
      end else if (busy_o && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        if (dir_lsb_q) begin
          sdata_o <= sr_q[0];
          sr_q    <= sr_q >> 1;
        end else begin
          sdata_o <= sr_q[WORD_W-1];
          sr_q    <= sr_q << 1;
        end
      end else begin
        busy_o  <= 1'b0;
        sdata_o <= 1'b0;
      end
    end
  end

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !sdata_o); // R11
  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (rst)
    load_o |=> busy_o); // R10
  AST_QUIET_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
    !act_edge_i |=> ($stable(sdata_o) && $stable(busy_o))); // R8

endmodule

// File: rtl/serial_word_tx.sv
module serial_word_tx #(
  parameter int HOST_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W = 2 * HOST_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              wr_hi_i,
  input  logic [HOST_W-1:0] wr_data_i,
  input  logic [2:0]        cfg_len_i,
  input  logic              cfg_clk_pol_i,
  input  logic              cfg_fs_pol_i,
  input  logic              cfg_lsb_first_i,
  input  logic              sclk_i,
  input  logic              fsync_i,
  output logic              sdata_o,
  output logic              tx_active_o,
  output logic              ready_o,
  output logic              underrun_o
);

  logic              act_edge, fs_act, load;
  logic [WORD_W-1:0] word;

  sertx_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .fsync_i(fsync_i),
    .clk_pol_i(cfg_clk_pol_i), .fs_pol_i(cfg_fs_pol_i),
    .act_edge_o(act_edge), .fs_act_o(fs_act)
  );

  sertx_hold_regs #(.HOST_W(HOST_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_hi_i(wr_hi_i),
    .wr_data_i(wr_data_i), .load_i(load), .word_o(word),
    .ready_o(ready_o), .underrun_o(underrun_o)
  );

  sertx_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .act_edge_i(act_edge), .fs_act_i(fs_act),
    .word_i(word), .cfg_len_i(cfg_len_i), .lsb_first_i(cfg_lsb_first_i),
    .load_o(load), .sdata_o(sdata_o), .busy_o(tx_active_o)
  );

endmodule

// File: tb/serial_word_tx_bench.sv
module serial_word_tx_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_hi = 1'b0;
  logic [15:0] wr_data = '0;
  logic [2:0]  cfg_len = '0;
  logic        cfg_clk_pol = 1'b0, cfg_fs_pol = 1'b0, cfg_lsb = 1'b0;
  logic        sclk = 1'b0, fsync = 1'b0;
  logic        sdata, active, ready, underrun;
  int          checks = 0, errors = 0;

  always #2 clk = ~clk;

  serial_word_tx u_serial_word_tx (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_hi_i(wr_hi), .wr_data_i(wr_data),
    .cfg_len_i(cfg_len), .cfg_clk_pol_i(cfg_clk_pol), .cfg_fs_pol_i(cfg_fs_pol),
    .cfg_lsb_first_i(cfg_lsb), .sclk_i(sclk), .fsync_i(fsync),
    .sdata_o(sdata), .tx_active_o(active), .ready_o(ready), .underrun_o(underrun)
  );

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic host_write(input logic hi, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_hi = hi; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_hi = 1'b0;
    @(negedge clk);
  endtask

  // one serial period: inactive edge, then active edge (R8), frame-sync level per R9
  task automatic serial_period(input logic fs);
    fsync = fs ^ cfg_fs_pol;
    sclk  = cfg_clk_pol;
    repeat (4) @(negedge clk);
    sclk  = ~cfg_clk_pol;
    repeat (4) @(negedge clk);
  endtask

  function automatic int len_of(input int code);
    case (code)
      0: return 8;
      1: return 12;
      2: return 16;
      3: return 20;
      4: return 24;
      default: return 32;
    endcase
  endfunction

  // send a word assuming frame starts at the first period; R2 bit count, R3/R4/R5 order
  task automatic send_word(input logic [31:0] w, input int len, input logic lsb_eff,
                           input logic expect_under, input logic refill, input logic [31:0] nxt);
    for (int i = 0; i < len; i++) begin
      logic exp_bit;
      string tag;
      serial_period(i == 0);
      exp_bit = lsb_eff ? w[i] : w[len-1-i];
      tag = lsb_eff ? "R4" : (len > 16 ? "R5" : "R3");
      chk(sdata === exp_bit, tag, sdata, exp_bit);
      chk(active === 1'b1, "R2", active, 1);
      if (i == 0) begin
        chk(ready === 1'b1, "R6 ready after load", ready, 1);
        chk(underrun === expect_under, "R7 underrun at frame start", underrun, expect_under);
        if (refill) begin
          host_write(1'b1, nxt[31:16]);
          chk(ready === 1'b1, "R6 high write keeps ready", ready, 1);
          host_write(1'b0, nxt[15:0]);
          chk(ready === 1'b0, "R6 low write clears ready", ready, 0);
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int idx = 0;
    for (int code = 0; code < 6; code++) begin
      for (int cfg = 0; cfg < 8; cfg++) begin
        logic [31:0] w1, w2;
        int len;
        logic lsb_eff;
        len = len_of(code);
        cfg_len     = 3'(code);
        cfg_clk_pol = cfg[0];   // R8
        cfg_fs_pol  = cfg[1];   // R9
        cfg_lsb     = cfg[2];
        lsb_eff     = cfg[2] && (len == 8);
        fsync       = cfg_fs_pol;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(sdata === 1'b0 && active === 1'b0, "R1 outputs", {sdata, active}, 0);
        chk(ready === 1'b1 && underrun === 1'b0, "R1 flags", {ready, underrun}, 2);
        w1 = 32'hA5C3_1E69 ^ (32'(idx) * 32'h9E37_79B9);
        w2 = ~w1 ^ 32'h0F0F_3C3C ^ 32'(idx);
        idx++;
        host_write(1'b1, w1[31:16]);
        chk(ready === 1'b1, "R6 high write keeps ready", ready, 1);
        host_write(1'b0, w1[15:0]);
        chk(ready === 1'b0, "R6 low write clears ready", ready, 0);
        send_word(w1, len, lsb_eff, 1'b0, 1'b1, w2);
        // R10 back-to-back: second word follows with no gap
        send_word(w2, len, lsb_eff, 1'b0, 1'b0, 32'h0);
        // R7 no refill: underrun, previous word resent
        send_word(w2, len, lsb_eff, 1'b1, 1'b0, 32'h0);
        serial_period(1'b0);
        chk(sdata === 1'b0 && active === 1'b0, "R11 idle after frame", {sdata, active}, 0);
        serial_period(1'b0);
        chk(sdata === 1'b0 && active === 1'b0, "R11 stays idle", {sdata, active}, 0);
        chk(underrun === 1'b1, "R7 underrun sticky", underrun, 1);
        host_write(1'b0, 16'h1234);
        chk(underrun === 1'b0, "R7 cleared by low write", underrun, 0);
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule